// File: doc/BRIEF.md
# Dirty-Line Flush Request Sizer

This block keeps a set of four modified-data flags for each line of a write-back data cache whose lines are 32 bytes long. There is one flag per 8-byte doubleword. Flags 0 and 1 cover the lower 16-byte half of the line (quadword 0), and flags 2 and 3 cover the upper half (quadword 1).

A store hit sets flags in the line it hits. When software or the replacement logic asks for a line to be flushed, the block reads that line's flags and decides how to write it back. It picks the smallest bus write that still covers every modified doubleword: 8, 16 or 32 bytes. It then presents a write request carrying that size and the address of the first byte to be written.

Stores to pages with the write-through attribute go straight to memory. They therefore never mark a line as modified, even when the line is already dirty through another mapping. A configuration input forces every flush of a dirty line to use a whole-line write.

The request is offered with a valid/ready handshake, and only one flush is in flight at a time. The flags of the line are cleared when the request is taken.

Top module: `flush_sizer`

## Requirements
- R1: After reset no line has any flag set, `wr_valid` is 0 and `fl_ready` is 1.
- R2: A store hit with `st_wthru` low sets the flag of every doubleword whose bit is set in `st_dw`. Bit k of `st_dw` is doubleword k of the line, at byte offset 8*k.
- R3: A store hit with `st_wthru` high leaves the line's flags unchanged. This holds even when the line already has flags set.
- R4: With `force_full` high when a flush is accepted, a line with any flag set produces a 32-byte request (`wr_size` = 2) at line offset 0.
- R5: With `force_full` low and exactly one flag set, the request is 8 bytes (`wr_size` = 0) at line offset 8*k, where k is the flagged doubleword.
- R6: With `force_full` low and flags set in only one quadword, two of them, the request is 16 bytes (`wr_size` = 1) at line offset 16*q, where q is that quadword.
- R7: With `force_full` low and flags set in both quadwords, the request is 32 bytes at line offset 0.
- R8: Flushing a line with no flags set produces no request. `fl_ready` stays 1.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_size` and `wr_addr` hold their values and `fl_ready` is 0. A flush command presented in that time is ignored and leaves the flags unchanged.
- R10: When the request is taken (`wr_valid` and `wr_ready` both high), the flags that were written are cleared. Flushing that line again produces no request.
- R11: A store to the line being flushed, in the same cycle the flush is accepted, is included in the size decision. The request address is `{fl_tag, 5'b0}` plus the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_full | input | 1 | Force whole-line writes on flush |
| st_valid | input | 1 | Store hit event |
| st_line | input | IW | Line index of the store |
| st_dw | input | 4 | Doublewords touched by the store |
| st_wthru | input | 1 | Store page is write-through |
| fl_valid | input | 1 | Flush command |
| fl_line | input | IW | Line index to flush |
| fl_tag | input | AW-5 | Upper address bits of the flushed line |
| fl_ready | output | 1 | Flush command can be accepted |
| wr_valid | output | 1 | Write request valid |
| wr_size | output | 2 | 0 = 8 bytes, 1 = 16 bytes, 2 = 32 bytes |
| wr_addr | output | AW | First byte address of the write |
| wr_ready | input | 1 | Bus takes the write request |

## Verification
The assertions check three properties on every cycle:
- the request fields hold steady while the bus stalls;
- no flush can be accepted while a request is pending;
- the address is aligned to the size, and a forced flush always yields a whole-line write.

How a size follows from a particular flag pattern, that write-through stores leave flags untouched, and that flags clear after the handshake all depend on the history of earlier stores. Only the bench's scenarios can show these, with its behavioural model of the flag array compared on every clock.

// File: rtl/flush_sizer.sv
module flush_sizer #(
  parameter int LINES = 16,
  parameter int AW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     force_full,
  input  logic                     st_valid,
  input  logic [$clog2(LINES)-1:0] st_line,
  input  logic [3:0]               st_dw,
  input  logic                     st_wthru,
  input  logic                     fl_valid,
  input  logic [$clog2(LINES)-1:0] fl_line,
  input  logic [AW-6:0]            fl_tag,
  output logic                     fl_ready,
  output logic                     wr_valid,
  output logic [1:0]               wr_size,
  output logic [AW-1:0]            wr_addr,
  input  logic                     wr_ready
);
  localparam int IW = $clog2(LINES);

  logic [3:0]    dirty [LINES];
  logic [IW-1:0] cap_line;
  logic [3:0]    cap_mask;

  wire [3:0] st_set = (st_valid && !st_wthru) ? st_dw : 4'b0;
  wire       hs     = wr_valid && wr_ready;
  wire       fl_acc = fl_valid && fl_ready;
  wire [3:0] snap   = dirty[fl_line] | ((st_line == fl_line) ? st_set : 4'b0);
  wire       lo     = |snap[1:0];
  wire       hi     = |snap[3:2];

  assign fl_ready = !wr_valid;

  logic [1:0] n_size;
  logic [4:0] n_off;
  always_comb begin
    n_size = 2'd2;
    n_off  = 5'd0;
    if (!force_full && !(lo && hi)) begin
      if ($onehot(snap)) begin
        n_size = 2'd0;
        unique case (snap)
          4'b0001: n_off = 5'd0;
          4'b0010: n_off = 5'd8;
          4'b0100: n_off = 5'd16;
          default: n_off = 5'd24;
        endcase
      end else begin
        n_size = 2'd1;
        n_off  = hi ? 5'd16 : 5'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_size  <= 2'd0;
      wr_addr  <= '0;
      cap_line <= '0;
      cap_mask <= '0;
    end else if (fl_acc && snap != 4'b0) begin
      wr_valid <= 1'b1;
      wr_size  <= n_size;
      wr_addr  <= {fl_tag, n_off};
      cap_line <= fl_line;
      cap_mask <= snap;
    end else if (hs) begin
      wr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) dirty[i] <= 4'b0;
    end else begin
      for (int i = 0; i < LINES; i++)
        dirty[i] <= ((hs && cap_line == IW'(i)) ? (dirty[i] & ~cap_mask) : dirty[i])
                  | ((st_line == IW'(i)) ? st_set : 4'b0);
    end
  end
endmodule

module flush_sizer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          force_full,
  input logic          fl_ready,
  input logic          wr_valid,
  input logic [1:0]    wr_size,
  input logic [AW-1:0] wr_addr,
  input logic          wr_ready
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_size) && $stable(wr_addr));
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !fl_ready);
  a_r4_force: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) && $past(force_full) |-> wr_size == 2'd2);
  a_r5_align8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_size == 2'd0 |-> wr_addr[2:0] == 3'd0);
  a_r6_align16: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_size == 2'd1 |-> wr_addr[3:0] == 4'd0);
  a_r7_align32: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_size == 2'd2 |-> wr_addr[4:0] == 5'd0);
  a_r7_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_size != 2'd3);
endmodule

bind flush_sizer flush_sizer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_full(force_full), .fl_ready(fl_ready),
  .wr_valid(wr_valid), .wr_size(wr_size), .wr_addr(wr_addr), .wr_ready(wr_ready)
);

// File: tb/flush_sizer_tb.sv
module flush_sizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 16;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic force_full = 0, st_valid = 0, st_wthru = 0, fl_valid = 0, wr_ready = 0;
  logic [3:0] st_line = 0, fl_line = 0, st_dw = 0;
  logic [AW-6:0] fl_tag = 0;
  logic fl_ready, wr_valid;
  logic [1:0] wr_size;
  logic [AW-1:0] wr_addr;

  int errors = 0, checks = 0;
  string cur_req = "R1";

  flush_sizer #(.LINES(LINES), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .force_full(force_full), .st_valid(st_valid),
    .st_line(st_line), .st_dw(st_dw), .st_wthru(st_wthru), .fl_valid(fl_valid),
    .fl_line(fl_line), .fl_tag(fl_tag), .fl_ready(fl_ready), .wr_valid(wr_valid),
    .wr_size(wr_size), .wr_addr(wr_addr), .wr_ready(wr_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  int m_dirty [LINES];
  bit m_valid;
  int m_size, m_line, m_mask;
  longint m_addr;

  always @(posedge clk) begin
    int set_b, d, lo, hi, n, off, sz, idx;
    bit hs;
    if (!rst_n) begin
      foreach (m_dirty[i]) m_dirty[i] = 0;
      m_valid = 0;
    end else begin
      hs = m_valid && wr_ready;
      set_b = (st_valid && !st_wthru) ? int'(st_dw) : 0;
      if (fl_valid && !m_valid) begin
        d = m_dirty[fl_line] | ((st_line == fl_line) ? set_b : 0);
        if (d != 0) begin
          lo = ((d & 3) != 0); hi = ((d & 12) != 0); n = $countones(d[3:0]);
          if (force_full || (lo && hi)) begin sz = 2; off = 0; end
          else if (n == 1) begin
            idx = 0; for (int k = 0; k < 4; k++) if (d[k]) idx = k;
            sz = 0; off = idx * 8;
          end else begin sz = 1; off = hi ? 16 : 0; end
          m_size = sz; m_addr = longint'(fl_tag) * 32 + off;
          m_line = fl_line; m_mask = d; m_valid = 1;
          hs = 0;
        end
      end
      for (int i = 0; i < LINES; i++) begin
        if (hs && m_line == i) m_dirty[i] = m_dirty[i] & ~m_mask;
        if (st_line == i) m_dirty[i] = m_dirty[i] | set_b;
      end
      if (hs) m_valid = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (wr_valid !== m_valid || fl_ready !== !m_valid ||
        (m_valid && (wr_size !== m_size[1:0] || wr_addr !== m_addr[AW-1:0]))) begin
      errors++;
      $display("FAIL %s model: valid=%b size=%0d addr=%h exp valid=%b size=%0d addr=%h",
               cur_req, wr_valid, wr_size, wr_addr, m_valid, m_size, m_addr[AW-1:0]);
    end
  end

  task automatic chk(string req, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic store(int line, int mask, bit wt);
    st_valid = 1; st_line = line[3:0]; st_dw = mask[3:0]; st_wthru = wt;
    @(negedge clk); st_valid = 0;
  endtask

  task automatic flush(int line, int tag);
    fl_valid = 1; fl_line = line[3:0]; fl_tag = tag[AW-6:0];
    @(negedge clk); fl_valid = 0;
  endtask

  task automatic expect_req(string req, int sz, longint addr);
    chk(req, wr_valid === 1'b1, "valid", longint'(wr_valid), 1);
    chk(req, wr_size === sz[1:0], "size", longint'(wr_size), sz);
    chk(req, wr_addr === addr[AW-1:0], "addr", longint'(wr_addr), addr);
  endtask

  task automatic take;
    wr_ready = 1; @(negedge clk); wr_ready = 0;
  endtask

  task automatic expect_none(string req);
    chk(req, wr_valid === 1'b0, "no request", longint'(wr_valid), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", wr_valid === 1'b0 && fl_ready === 1'b1, "reset outputs", {wr_valid, fl_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R5";
    store(3, 4'b0100, 0);
    flush(3, 'h100);
    expect_req("R5", 0, 'h100 * 32 + 16);
    take();
    cur_req = "R10";
    flush(3, 'h100);
    expect_none("R10");
    cur_req = "R8";
    flush(12, 'h7);
    expect_none("R8");
    chk("R8", fl_ready === 1'b1, "fl_ready", longint'(fl_ready), 1);

    cur_req = "R6";
    store(5, 4'b1000, 0); store(5, 4'b0100, 0);
    flush(5, 'h55);
    expect_req("R6", 1, 'h55 * 32 + 16);
    take();
    store(6, 4'b0011, 0);
    flush(6, 'h66);
    expect_req("R6", 1, 'h66 * 32);
    take();

    cur_req = "R7";
    store(7, 4'b0001, 0); store(7, 4'b1000, 0);
    flush(7, 'h77);
    expect_req("R7", 2, 'h77 * 32);
    take();

    cur_req = "R2";
    store(2, 4'b0110, 0);
    flush(2, 'h22);
    expect_req("R2", 2, 'h22 * 32);
    take();
    store(1, 4'b1100, 0);
    flush(1, 'h11);
    expect_req("R2", 1, 'h11 * 32 + 16);
    take();

    cur_req = "R4";
    force_full = 1;
    store(8, 4'b0010, 0);
    flush(8, 'h88);
    expect_req("R4", 2, 'h88 * 32);
    take();
    flush(8, 'h88);
    expect_none("R4");
    force_full = 0;

    cur_req = "R3";
    store(9, 4'b0001, 0); store(9, 4'b1000, 1);
    flush(9, 'h99);
    expect_req("R3", 0, 'h99 * 32);
    take();
    store(10, 4'b1111, 1);
    flush(10, 'hAA);
    expect_none("R3");

    cur_req = "R9";
    store(4, 4'b0001, 0); store(11, 4'b0010, 0);
    flush(4, 'h44);
    flush(11, 'hBB);
    @(negedge clk);
    expect_req("R9", 0, 'h44 * 32);
    chk("R9", fl_ready === 1'b0, "fl_ready busy", longint'(fl_ready), 0);
    take();
    expect_none("R9");
    flush(11, 'hBB);
    expect_req("R9", 0, 'hBB * 32 + 8);
    take();

    cur_req = "R11";
    store(13, 4'b0001, 0);
    st_valid = 1; st_line = 13; st_dw = 4'b0100; st_wthru = 0;
    flush(13, 'hDD);
    st_valid = 0;
    expect_req("R11", 2, 'hDD * 32);
    take();

    cur_req = "R9";
    for (int n = 0; n < 2000; n++) begin
      st_valid = $urandom_range(0, 1); st_line = 4'($urandom_range(0, 3));
      st_dw = 4'($urandom); st_wthru = ($urandom_range(0, 3) == 0);
      fl_valid = ($urandom_range(0, 2) == 0); fl_line = 4'($urandom_range(0, 3));
      fl_tag = 27'($urandom); wr_ready = $urandom_range(0, 1);
      force_full = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    st_valid = 0; fl_valid = 0; wr_ready = 1;
    @(negedge clk); @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule